// File: doc/BRIEF.md
# I2C Master Start-Condition Generator

This block produces the opening Start condition of an I2C master transfer. The host sets the start-enable bit in a small control register. If both bus lines are seen high, the block waits one baud period with SDA released. It then pulls SDA low while SCL is still high, which is the Start condition itself. It holds SDA low for a second baud period and then reports completion. A down-counter, reloaded from a 7-bit host value at each phase, times both periods. SCL and SDA reach the control logic only through a two-flop synchronizer. SDA is driven open-drain: `sda_oe` high means the line is pulled low.

A bus collision ends the sequence early. One case is a line already low when the request is taken. The other is SCL dropping, or SDA being seen low, while SDA is still released. The block then sets a sticky collision flag, clears start-enable and releases SDA. Once the sequence is running, the block does not queue new work. Control-register writes are dropped, and a transmit-buffer write is refused with a write-collision flag. After completion SDA stays low until the next accepted control write, which hands the bus back.

Top module: `i2c_start_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `ctrl_q`, `start_en`, `txbuf_q`, all four flags and `sda_oe` are 0.
- R2: Control bit 0 is the start-enable bit. A control write accepted while idle, with bit 0 set and both synchronized lines high, makes `start_en` read 1 from the next clock edge. SDA then stays released (`sda_oe`=0) for `reload_val`+1 clocks after that edge.
- R3: The baud counter reaches zero and both synchronized lines are high. On the same edge, `sda_oe` rises to 1 and `start_det` is set.
- R4: A second period of `reload_val`+1 clocks follows. At its end `start_en` clears and `done_flag` sets, while `sda_oe` stays 1. After that the counter stays stopped and SDA stays held low with no further host action.
- R5: A start request is aborted if either synchronized line is low when the request is accepted. On the edge that takes the write, `bcol_flag` sets and `start_en` reads 0, and SDA is never driven.
- R6: While SDA is still released, a synchronized SCL low aborts the sequence, as does a synchronized SDA low at the first timeout. The abort sets `bcol_flag`, clears `start_en` and leaves `start_det` clear. An SCL pulse at the pins is seen by the control logic 2 clocks later. SCL low after SDA has been driven low does not abort.
- R7: A transmit-buffer write while `start_en` is 1 sets `wcol_flag` and leaves `txbuf_q` unchanged. At any other time the write loads `txbuf_q` and does not touch `wcol_flag`.
- R8: Control writes made while `start_en` is 1 are ignored in every bit, and a write of bit 0 = 0 does not cancel the running sequence.
- R9: The flags are sticky. `flag_clr` bit 0 clears `start_det`, bit 1 clears `done_flag`, bit 2 clears `bcol_flag` and bit 3 clears `wcol_flag`. If a set and a clear of the same flag fall in one cycle, the set wins.
- R10: A control write accepted after completion releases SDA (`sda_oe`=0 on the next edge). Its bits 4:1 are stored, and its bit 0 is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | CTRL_W (5) | Control write data, bit 0 = start enable |
| reload_val | input | RELOAD_W (7) | Baud counter reload value |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| txbuf_wdata | input | DATA_W (8) | Transmit-buffer write data |
| flag_clr | input | 4 | Per-flag clear pulses (see R9) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| ctrl_q | output | CTRL_W (5) | Control register contents |
| start_en | output | 1 | Start-enable bit, 1 while a sequence runs |
| txbuf_q | output | DATA_W (8) | Transmit-buffer contents |
| start_det | output | 1 | Start condition issued (sticky) |
| done_flag | output | 1 | Start sequence completed (sticky) |
| bcol_flag | output | 1 | Bus collision (sticky) |
| wcol_flag | output | 1 | Write collision (sticky) |
| sda_oe | output | 1 | Open-drain SDA pull-low enable |

## Verification
A sequencer stuck in the wrong phase shows up at the pins within one baud period. Either `sda_oe` rises a clock early or late, or `start_en` never falls. A counter reload that is off by one moves the edge of `sda_oe` or `done_flag` by exactly one clock, so each phase boundary is sampled on the exact clock and its neighbour. A lost busy indication is visible at once, because `ctrl_q` or `txbuf_q` changes under a write that should have been dropped. A missed collision shows as `start_det` or `sda_oe` rising when `bcol_flag` should have risen instead.

// File: rtl/i2c_start_pkg.sv
// Shared types for the Start-condition generator: sequencer states and
// the bit positions of the sticky flag vector (host clear pulses use them).
package i2c_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_T1 = 3'd1,
        ST_WAIT_T2 = 3'd2,
        ST_DONE    = 3'd3,
        ST_ABORT   = 3'd4
    } start_state_e;

    localparam int FLG_SDET = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_BCOL = 2;
    localparam int FLG_WCOL = 3;
    localparam int FLG_N    = 4;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-flop synchronizer for the bus lines.
// Assumes STAGES >= 2. Resets to all ones, the idle level of a pulled-up bus.
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw line levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_baud_cnt.sv
// Reloadable baud-period down-counter. A load sets the count to the reload
// value and starts it, so one period lasts reload+1 clocks. The timeout is
// high for one cycle at count zero, after which the counter stops unless
// reloaded on that same edge. A halt stops it at once.
module i2c_baud_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         halt,
    input  logic [W-1:0] reload_val,
    output logic         tmo
);

    logic [W-1:0] cnt_q;
    logic         run_q;

    // Count down while running; a load has priority over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= reload_val;
            run_q <= 1'b1;
        end else if (halt) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tmo = run_q && (cnt_q == '0);

endmodule

// File: rtl/i2c_start_fsm.sv
// Start sequencer. It checks the bus when a request arrives, times the
// released and low phases of SDA with the baud counter, and detects
// collisions while SDA is still released. Assumes scl_s/sda_s are already
// synchronized. Event outputs are combinational and take effect on the same
// edge as the matching state change.
module i2c_start_fsm
    import i2c_start_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rel_req,
    input  logic scl_s,
    input  logic sda_s,
    input  logic tmo,
    output logic cnt_load,
    output logic cnt_halt,
    output logic ev_sda_low,
    output logic ev_done,
    output logic ev_abort,
    output logic is_idle,
    output logic is_done,
    output logic sda_oe
);

    start_state_e state_q, state_d;

    // Next-state and event decode.
    always_comb begin
        state_d    = state_q;
        cnt_load   = 1'b0;
        cnt_halt   = 1'b0;
        ev_sda_low = 1'b0;
        ev_done    = 1'b0;
        ev_abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (scl_s && sda_s) begin
                        state_d  = ST_WAIT_T1;
                        cnt_load = 1'b1;
                    end else begin
                        state_d  = ST_ABORT;
                        ev_abort = 1'b1;
                    end
                end
            end
            ST_WAIT_T1: begin
                if (!scl_s || (tmo && !sda_s)) begin
                    state_d  = ST_ABORT;
                    ev_abort = 1'b1;
                    cnt_halt = 1'b1;
                end else if (tmo) begin
                    state_d    = ST_WAIT_T2;
                    cnt_load   = 1'b1;
                    ev_sda_low = 1'b1;
                end
            end
            ST_WAIT_T2: begin
                if (tmo) begin
                    state_d = ST_DONE;
                    ev_done = 1'b1;
                end
            end
            ST_DONE: begin
                if (rel_req) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign is_idle = (state_q == ST_IDLE);
    assign is_done = (state_q == ST_DONE);
    assign sda_oe  = (state_q == ST_WAIT_T2) || (state_q == ST_DONE);

endmodule

// File: rtl/i2c_start_regs.sv
// Host-side register file: control bits, transmit buffer and sticky flags.
// While the start-enable bit is 1, control writes are dropped and buffer
// writes are refused with a write-collision flag. Hardware events set
// flags with priority over host clears.
module i2c_start_regs
    import i2c_start_pkg::*;
#(
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              txbuf_wr,
    input  logic [DATA_W-1:0] txbuf_wdata,
    input  logic [FLG_N-1:0]  flag_clr,
    input  logic              is_idle,
    input  logic              is_done,
    input  logic              ev_sda_low,
    input  logic              ev_done,
    input  logic              ev_abort,
    output logic              req,
    output logic              rel_req,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] txbuf_q,
    output logic [FLG_N-1:0]  flags_q
);

    logic              busy;
    logic              ctrl_acc;
    logic [CTRL_W-1:0] ctrl_wmask;
    logic [FLG_N-1:0]  set_vec;

    assign busy     = ctrl_q[0];
    assign ctrl_acc = ctrl_wr && !busy;
    assign req      = ctrl_acc && ctrl_wdata[0] && is_idle;
    assign rel_req  = ctrl_acc && is_done;

    // Form the stored control value: start bit is only taken when idle.
    always_comb begin
        ctrl_wmask    = ctrl_wdata;
        ctrl_wmask[0] = ctrl_wdata[0] && is_idle;
    end

    // Control register; completion or abort clears the start bit last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_acc) begin
                ctrl_q <= ctrl_wmask;
            end
            if (ev_done || ev_abort) begin
                ctrl_q[0] <= 1'b0;
            end
        end
    end

    // Transmit buffer, loaded only outside a running sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_q <= '0;
        end else if (txbuf_wr && !busy) begin
            txbuf_q <= txbuf_wdata;
        end
    end

    // Collect the hardware set events per flag.
    always_comb begin
        set_vec           = '0;
        set_vec[FLG_SDET] = ev_sda_low;
        set_vec[FLG_DONE] = ev_done;
        set_vec[FLG_BCOL] = ev_abort;
        set_vec[FLG_WCOL] = txbuf_wr && busy;
    end

    // Sticky flags: clear by host pulse, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | set_vec;
        end
    end

endmodule

// File: rtl/i2c_start_gen.sv
// Top of the I2C master Start-condition generator. It connects the line
// synchronizer, baud counter, sequencer and host registers. Assumes the
// bus lines are external pull-ups; SDA is only ever pulled low via sda_oe.
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int RELOAD_W    = 7,
    parameter int CTRL_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                txbuf_wr,
    input  logic [DATA_W-1:0]   txbuf_wdata,
    input  logic [FLG_N-1:0]    flag_clr,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic                start_en,
    output logic [DATA_W-1:0]   txbuf_q,
    output logic                start_det,
    output logic                done_flag,
    output logic                bcol_flag,
    output logic                wcol_flag,
    output logic                sda_oe
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_raw, lines_s;
    logic             scl_s, sda_s;
    logic             tmo, cnt_load, cnt_halt;
    logic             ev_sda_low, ev_done, ev_abort;
    logic             is_idle, is_done, req, rel_req;
    logic [FLG_N-1:0] flags_q;

    assign lines_raw = {scl_in, sda_in};
    assign scl_s     = lines_s[1];
    assign sda_s     = lines_s[0];

    i2c_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lines_raw),
        .q     (lines_s)
    );

    i2c_baud_cnt #(.W(RELOAD_W)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .halt       (cnt_halt),
        .reload_val (reload_val),
        .tmo        (tmo)
    );

    i2c_start_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .rel_req    (rel_req),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .tmo        (tmo),
        .cnt_load   (cnt_load),
        .cnt_halt   (cnt_halt),
        .ev_sda_low (ev_sda_low),
        .ev_done    (ev_done),
        .ev_abort   (ev_abort),
        .is_idle    (is_idle),
        .is_done    (is_done),
        .sda_oe     (sda_oe)
    );

    i2c_start_regs #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .txbuf_wr    (txbuf_wr),
        .txbuf_wdata (txbuf_wdata),
        .flag_clr    (flag_clr),
        .is_idle     (is_idle),
        .is_done     (is_done),
        .ev_sda_low  (ev_sda_low),
        .ev_done     (ev_done),
        .ev_abort    (ev_abort),
        .req         (req),
        .rel_req     (rel_req),
        .ctrl_q      (ctrl_q),
        .txbuf_q     (txbuf_q),
        .flags_q     (flags_q)
    );

    assign start_en  = ctrl_q[0];
    assign start_det = flags_q[FLG_SDET];
    assign done_flag = flags_q[FLG_DONE];
    assign bcol_flag = flags_q[FLG_BCOL];
    assign wcol_flag = flags_q[FLG_WCOL];

endmodule

// File: rtl/i2c_start_chk.sv
// Port-level property checker for i2c_start_gen, attached by bind.
module i2c_start_chk #(
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              txbuf_wr,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              start_en,
    input logic [DATA_W-1:0] txbuf_q,
    input logic              start_det,
    input logic              done_flag,
    input logic              bcol_flag,
    input logic              wcol_flag,
    input logic              sda_oe
);

    // R2
    sda_free_at_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_en) |-> !sda_oe);

    // R3
    sda_pull_marks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> start_det && start_en);

    // R4
    done_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !start_en && sda_oe);

    // R5
    collision_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol_flag) |-> !start_en && !sda_oe);

    // R7
    busy_buffer_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && txbuf_wr) |=> wcol_flag && (txbuf_q == $past(txbuf_q)));

    // R8
    busy_ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && ctrl_wr) |=> ((ctrl_q >> 1) == ($past(ctrl_q) >> 1)));

endmodule

bind i2c_start_gen i2c_start_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .txbuf_wr  (txbuf_wr),
    .ctrl_q    (ctrl_q),
    .start_en  (start_en),
    .txbuf_q   (txbuf_q),
    .start_det (start_det),
    .done_flag (done_flag),
    .bcol_flag (bcol_flag),
    .wcol_flag (wcol_flag),
    .sda_oe    (sda_oe)
);

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [6:0] reload_val = '0;
    logic       txbuf_wr = 1'b0;
    logic [7:0] txbuf_wdata = '0;
    logic [3:0] flag_clr = '0;
    logic       scl_ext = 1'b1;
    logic       sda_ext = 1'b1;
    logic       sda_in;
    logic [4:0] ctrl_q;
    logic       start_en, start_det, done_flag, bcol_flag, wcol_flag, sda_oe;
    logic [7:0] txbuf_q;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // Wired-AND SDA: other devices via sda_ext, the design via sda_oe.
    assign sda_in = sda_ext & ~sda_oe;

    i2c_start_gen dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .reload_val(reload_val), .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
        .flag_clr(flag_clr), .scl_in(scl_ext), .sda_in(sda_in),
        .ctrl_q(ctrl_q), .start_en(start_en), .txbuf_q(txbuf_q),
        .start_det(start_det), .done_flag(done_flag), .bcol_flag(bcol_flag),
        .wcol_flag(wcol_flag), .sda_oe(sda_oe)
    );

    // {reload[6:0], scl, sda, expect_start}
    localparam int NV = 7;
    localparam logic [9:0] VEC [NV] = '{
        {7'd3,   1'b1, 1'b1, 1'b1},
        {7'd0,   1'b1, 1'b1, 1'b1},
        {7'd10,  1'b1, 1'b1, 1'b1},
        {7'd127, 1'b1, 1'b1, 1'b1},
        {7'd5,   1'b0, 1'b0, 1'b0},
        {7'd5,   1'b0, 1'b1, 1'b0},
        {7'd5,   1'b1, 1'b0, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        ctrl_wdata = v;
        ctrl_wr    = 1'b1;
        tick(1);
        ctrl_wr    = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", "ctrl_q", ctrl_q, 0);
        chk("R1", "flags", {start_det, done_flag, bcol_flag, wcol_flag}, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "txbuf_q", txbuf_q, 0);

        // Table walk: normal starts and request-time collisions
        for (int v = 0; v < NV; v++) begin
            int n;
            n = int'(VEC[v][9:3]);
            scl_ext    = VEC[v][2];
            sda_ext    = VEC[v][1];
            reload_val = VEC[v][9:3];
            do_reset();
            wr_ctrl(5'b00001);  // now after edge P1
            if (VEC[v][0]) begin
                chk("R2", "start_en", start_en, 1);
                tick(n);        // after P(N+1)
                chk("R2", "sda_oe released", sda_oe, 0);
                tick(1);        // after P(N+2)
                chk("R3", "sda_oe", sda_oe, 1);
                chk("R3", "start_det", start_det, 1);
                tick(n);        // after P(2N+2)
                chk("R4", "start_en still", start_en, 1);
                chk("R4", "done early", done_flag, 0);
                tick(1);        // after P(2N+3)
                chk("R4", "done", done_flag, 1);
                chk("R4", "start_en cleared", start_en, 0);
                chk("R4", "sda held", sda_oe, 1);
            end else begin
                chk("R5", "bcol", bcol_flag, 1);
                chk("R5", "start_en", start_en, 0);
                tick(3);
                chk("R5", "sda_oe", sda_oe, 0);
                chk("R5", "start_det", start_det, 0);
            end
        end
        scl_ext = 1'b1;
        sda_ext = 1'b1;

        // R7/R8/R9/R10/R4 directed sequence
        reload_val = 7'd20;
        do_reset();
        txbuf_wdata = 8'h3C;
        txbuf_wr    = 1'b1;
        tick(1);
        txbuf_wr    = 1'b0;
        chk("R7", "idle load", txbuf_q, 8'h3C);
        chk("R7", "no wcol idle", wcol_flag, 0);
        wr_ctrl(5'b00001);      // after P1
        tick(1);                // after P2
        ctrl_wdata  = 5'b11110;
        ctrl_wr     = 1'b1;
        txbuf_wdata = 8'hA5;
        txbuf_wr    = 1'b1;
        tick(1);                // after P3
        ctrl_wr  = 1'b0;
        txbuf_wr = 1'b0;
        chk("R8", "ctrl ignored", ctrl_q, 5'b00001);
        chk("R7", "wcol", wcol_flag, 1);
        chk("R7", "buffer kept", txbuf_q, 8'h3C);
        tick(40);               // after P43
        chk("R8", "not cancelled", done_flag, 1);
        flag_clr = 4'b1000;
        tick(1);
        flag_clr = 4'b0000;
        chk("R9", "wcol cleared", wcol_flag, 0);
        chk("R9", "others kept", {start_det, done_flag}, 2'b11);
        tick(30);
        chk("R4", "still held", sda_oe, 1);
        wr_ctrl(5'b00011);
        chk("R10", "ctrl stored", ctrl_q, 5'b00010);
        chk("R10", "released", sda_oe, 0);
        txbuf_wdata = 8'h5A;
        txbuf_wr    = 1'b1;
        tick(1);
        txbuf_wr    = 1'b0;
        chk("R7", "load after done", txbuf_q, 8'h5A);

        // R9 set wins over clear: write collision with simultaneous clear
        reload_val = 7'd5;
        do_reset();
        wr_ctrl(5'b00001);
        txbuf_wr = 1'b1;
        flag_clr = 4'b1000;
        tick(1);
        txbuf_wr = 1'b0;
        flag_clr = 4'b0000;
        chk("R9", "set wins", wcol_flag, 1);

        // R6 SCL low during released phase aborts
        reload_val = 7'd20;
        do_reset();
        wr_ctrl(5'b00001);      // after P1
        tick(2);                // after P3
        scl_ext = 1'b0;
        tick(2);                // after P5
        chk("R6", "no abort yet", bcol_flag, 0);
        tick(1);                // after P6
        chk("R6", "bcol", bcol_flag, 1);
        chk("R6", "start_en", start_en, 0);
        scl_ext = 1'b1;
        tick(30);
        chk("R6", "no start", start_det, 0);
        flag_clr = 4'b0100;
        tick(1);
        flag_clr = 4'b0000;
        chk("R9", "bcol cleared", bcol_flag, 0);

        // R6 SCL low after SDA pulled low is ignored
        reload_val = 7'd3;
        do_reset();
        wr_ctrl(5'b00001);      // after P1
        tick(4);                // after P5
        scl_ext = 1'b0;
        tick(4);                // after P9
        chk("R6", "done despite scl", done_flag, 1);
        chk("R6", "no bcol", bcol_flag, 0);
        scl_ext = 1'b1;

        summary();
    end

endmodule